// File: doc/BRIEF.md
# Recommended-minimum sentence time and date extractor

This block watches a byte stream from a satellite navigation receiver and picks out the UTC time of day and the calendar date from the recommended-minimum sentence. Bytes arrive one per cycle when a valid strobe is high. Every other cycle is idle and changes nothing. The block hunts for a `$`, checks that the sentence identifier is `GPRMC`, and then counts commas to find the fields it needs. The time sits in data field 1 and the status letter in field 2. The date sits in field 9. Position, speed and track are skipped.

The block also computes the XOR of every byte between `$` and `*` and compares it with the two hex digits that follow the `*`. Once the closing carriage return and line feed arrive, it registers the decoded values in binary, a data-valid flag, a checksum flag and an error flag. In that same cycle it raises a one-cycle done pulse. The values then hold until the next complete sentence. A host uses the block to time-stamp events or to load a real-time counter once per sentence, and it takes the values only when done is high and error is low.

Top module: `rmc_tod_parser`

## Requirements
- R1: After reset all value outputs, `data_valid`, `cksum_ok`, `err` and `done` are 0.
- R2: Data field 1 (the first field after the identifier) carries six decimal digits in hour, minute, second order. They appear in binary on `hour`, `minute` and `second`. Any characters after the sixth in that field (for example a fraction such as `.00`) are ignored.
- R3: Data field 9 carries six decimal digits in day, month, two-digit-year order. They appear in binary on `day`, `month` and `year`.
- R4: `data_valid` is 1 when the first character of data field 2 is `A` (0x41), and 0 for any other character such as `V`.
- R5: `cksum_ok` is 1 only when the two characters after `*` are hex digits whose value equals the XOR of all bytes strictly between `$` and `*`. When it is 0, `err` is 1.
- R6: Hex checksum letters are accepted in upper case (`A`-`F`) and in lower case (`a`-`f`).
- R7: `err` is 1 when the hour exceeds 23, the minute or second exceeds 59, the day is outside 1..31, or the month is outside 1..12.
- R8: `err` is 1 when any of the first six characters of the time or date field is not a decimal digit, or when that field has fewer than six characters.
- R9: Bytes before the first `$` are ignored. A `$` received at any point abandons the sentence in progress and starts a new one.
- R10: A sentence whose identifier is not `GPRMC` followed by a comma produces no done pulse and leaves all outputs unchanged.
- R11: `done` is a single-cycle pulse in the cycle after a line feed (0x0A) is accepted directly after a carriage return (0x0D), which in turn follows the second checksum character. The outputs change only in a cycle in which `done` is 1.
- R12: Cycles with `byte_vld` low have no effect. A sentence delivered with idle cycles between its bytes gives the same result as one delivered without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Received character |
| byte_vld | input | 1 | `byte_in` carries a character this cycle |
| hour | output | 5 | UTC hour, binary |
| minute | output | 6 | UTC minute, binary |
| second | output | 6 | UTC second, binary |
| day | output | 5 | Day of month, binary |
| month | output | 4 | Month, binary |
| year | output | 7 | Two-digit year, binary |
| data_valid | output | 1 | Status field was `A` |
| cksum_ok | output | 1 | Received checksum matched |
| err | output | 1 | Range, format or checksum fault in the sentence |
| done | output | 1 | One-cycle pulse: the outputs above were just updated |

## Verification
The range checks and the checksum comparison both feed the error flag in the same done cycle. The bench provokes this with sentences that carry an out-of-range hour together with a checksum that has one bit flipped. It then judges that `err` is high and `cksum_ok` is low at once, and also checks each fault on its own. A second meeting point is a `$` that arrives while a sentence is still half parsed. Here the restart must clear the partly collected digits and the running XOR in the same cycle, so the following complete sentence has to decode exactly as if it stood alone. Time, date and year values are swept over the full legal range and one step beyond each edge, and the expected fields, flags and checksums are worked out arithmetically in the bench.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

   localparam logic [7:0] CH_DOLLAR = 8'h24;
   localparam logic [7:0] CH_STAR   = 8'h2A;
   localparam logic [7:0] CH_COMMA  = 8'h2C;
   localparam logic [7:0] CH_CR     = 8'h0D;
   localparam logic [7:0] CH_LF     = 8'h0A;
   localparam logic [7:0] CH_VALID  = 8'h41;

   typedef enum logic [2:0] {
      ST_HUNT, ST_HDR, ST_BODY, ST_HEX1, ST_HEX2, ST_CR, ST_LF
   } rmc_state_e;

   function automatic logic is_dec(input logic [7:0] c);
      return (c >= 8'h30) && (c <= 8'h39);
   endfunction

   // {valid, nibble}
   function automatic logic [4:0] hex_dec(input logic [7:0] c);
      if (is_dec(c))
         return {1'b1, c[3:0]};
      else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
         return {1'b1, c[3:0] + 4'd9};
      else
         return 5'd0;
   endfunction

   // identifier text after '$', including the closing comma
   function automatic logic [7:0] hdr_char(input logic [2:0] i);
      case (i)
         3'd0:    return 8'h47;
         3'd1:    return 8'h50;
         3'd2:    return 8'h52;
         3'd3:    return 8'h4D;
         3'd4:    return 8'h43;
         3'd5:    return CH_COMMA;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/rmc_digit_field.sv
module rmc_digit_field import rmc_pkg::*; #(
   parameter int NDIG   = 6,
   parameter int PAIR_W = 7
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                clr,
   input  logic                                push,
   input  logic [7:0]                          ch,
   output logic                                ok,
   output logic [NDIG/2-1:0][PAIR_W-1:0]       pair_val
);

   localparam int NPAIR = NDIG / 2;
   localparam int CNT_W = $clog2(NDIG + 1);

   generate
      if ((NDIG % 2) != 0 || NDIG < 2)
         $error("digit count must be even and at least two");
      if (PAIR_W < 7)
         $error("pair width must hold 99");
   endgenerate

   logic [3:0]       dig [NDIG];
   logic [CNT_W-1:0] cnt;
   logic             bad;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
         bad <= 1'b0;
         for (int i = 0; i < NDIG; i++) dig[i] <= 4'd0;
      end else if (push && (cnt < CNT_W'(NDIG))) begin
         cnt <= cnt + 1'b1;
         if (is_dec(ch)) dig[cnt] <= ch[3:0];
         else            bad      <= 1'b1;
      end
   end

   assign ok = (cnt == CNT_W'(NDIG)) && !bad;

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      assign pair_val[k] = PAIR_W'(dig[2*k]) * PAIR_W'(10) + PAIR_W'(dig[2*k+1]);
   end

endmodule

// File: rtl/rmc_xor_check.sv
module rmc_xor_check import rmc_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       acc_en,
   input  logic       hi_en,
   input  logic       lo_en,
   input  logic [7:0] ch,
   output logic       match
);

   logic [7:0] acc;
   logic [7:0] rx;
   logic       rx_bad;
   logic [4:0] hv;

   assign hv = hex_dec(ch);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc    <= 8'd0;
         rx     <= 8'd0;
         rx_bad <= 1'b0;
      end else begin
         if (acc_en) acc <= acc ^ ch;
         if (hi_en) begin
            rx[7:4] <= hv[3:0];
            if (!hv[4]) rx_bad <= 1'b1;
         end
         if (lo_en) begin
            rx[3:0] <= hv[3:0];
            if (!hv[4]) rx_bad <= 1'b1;
         end
      end
   end

   assign match = !rx_bad && (rx == acc);

endmodule

// File: rtl/rmc_tod_parser.sv
module rmc_tod_parser import rmc_pkg::*; #(
   parameter int NDIG       = 6,
   parameter int PAIR_W     = 7,
   parameter int FLD_W      = 4,
   parameter int TIME_FLD   = 1,
   parameter int STATUS_FLD = 2,
   parameter int DATE_FLD   = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] byte_in,
   input  logic       byte_vld,
   output logic [4:0] hour,
   output logic [5:0] minute,
   output logic [5:0] second,
   output logic [4:0] day,
   output logic [3:0] month,
   output logic [6:0] year,
   output logic       data_valid,
   output logic       cksum_ok,
   output logic       err,
   output logic       done
);

   localparam int NPAIR   = NDIG / 2;
   localparam int FLD_MAX = (1 << FLD_W) - 1;

   generate
      if (NDIG != 6)
         $error("time and date fields are three digit pairs");
      if (TIME_FLD < 1 || STATUS_FLD < 1 || DATE_FLD < 1)
         $error("data fields are numbered from one");
      if (TIME_FLD >= FLD_MAX || STATUS_FLD >= FLD_MAX || DATE_FLD >= FLD_MAX)
         $error("field counter too narrow");
      if (TIME_FLD == DATE_FLD || TIME_FLD == STATUS_FLD || STATUS_FLD == DATE_FLD)
         $error("field positions must differ");
   endgenerate

   rmc_state_e        state;
   logic [2:0]        hdr_idx;
   logic [FLD_W-1:0]  fld;
   logic              fld_seen;
   logic              status_r;

   logic start, hdr_hit, body_chr, t_push, d_push, acc_en, hi_en, lo_en, finish;
   logic t_ok, d_ok, ck_match, rng_ok;
   logic [NPAIR-1:0][PAIR_W-1:0] t_pair, d_pair;

   assign start    = byte_vld && (byte_in == CH_DOLLAR);
   assign hdr_hit  = (byte_in == hdr_char(hdr_idx));
   assign body_chr = byte_vld && !start && (state == ST_BODY) &&
                     (byte_in != CH_STAR) && (byte_in != CH_COMMA);
   assign t_push   = body_chr && (fld == FLD_W'(TIME_FLD));
   assign d_push   = body_chr && (fld == FLD_W'(DATE_FLD));
   assign acc_en   = byte_vld && !start &&
                     (((state == ST_HDR) && hdr_hit) ||
                      ((state == ST_BODY) && (byte_in != CH_STAR)));
   assign hi_en    = byte_vld && !start && (state == ST_HEX1);
   assign lo_en    = byte_vld && !start && (state == ST_HEX2);
   assign finish   = byte_vld && (state == ST_LF) && (byte_in == CH_LF);

   rmc_digit_field #(.NDIG(NDIG), .PAIR_W(PAIR_W)) time_fld_i (
      .clk(clk), .rst_n(rst_n), .clr(start), .push(t_push), .ch(byte_in),
      .ok(t_ok), .pair_val(t_pair));

   rmc_digit_field #(.NDIG(NDIG), .PAIR_W(PAIR_W)) date_fld_i (
      .clk(clk), .rst_n(rst_n), .clr(start), .push(d_push), .ch(byte_in),
      .ok(d_ok), .pair_val(d_pair));

   rmc_xor_check xor_i (
      .clk(clk), .rst_n(rst_n), .clr(start), .acc_en(acc_en),
      .hi_en(hi_en), .lo_en(lo_en), .ch(byte_in), .match(ck_match));

   assign rng_ok = (t_pair[0] < PAIR_W'(24)) && (t_pair[1] < PAIR_W'(60)) &&
                   (t_pair[2] < PAIR_W'(60)) &&
                   (d_pair[0] != '0) && (d_pair[0] < PAIR_W'(32)) &&
                   (d_pair[1] != '0) && (d_pair[1] < PAIR_W'(13)) &&
                   (d_pair[2] < PAIR_W'(100));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_HUNT;
         hdr_idx    <= 3'd0;
         fld        <= '0;
         fld_seen   <= 1'b0;
         status_r   <= 1'b0;
         hour       <= '0;
         minute     <= '0;
         second     <= '0;
         day        <= '0;
         month      <= '0;
         year       <= '0;
         data_valid <= 1'b0;
         cksum_ok   <= 1'b0;
         err        <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            state    <= ST_HDR;
            hdr_idx  <= 3'd0;
            status_r <= 1'b0;
            fld_seen <= 1'b0;
         end else if (byte_vld) begin
            case (state)
               ST_HDR: begin
                  if (!hdr_hit)              state   <= ST_HUNT;
                  else if (hdr_idx == 3'd5) begin
                     state    <= ST_BODY;
                     fld      <= FLD_W'(1);
                     fld_seen <= 1'b0;
                  end else                   hdr_idx <= hdr_idx + 3'd1;
               end
               ST_BODY: begin
                  if (byte_in == CH_STAR) state <= ST_HEX1;
                  else if (byte_in == CH_COMMA) begin
                     if (fld != FLD_W'(FLD_MAX)) fld <= fld + 1'b1;
                     fld_seen <= 1'b0;
                  end else begin
                     fld_seen <= 1'b1;
                     if (fld == FLD_W'(STATUS_FLD) && !fld_seen)
                        status_r <= (byte_in == CH_VALID);
                  end
               end
               ST_HEX1: state <= ST_HEX2;
               ST_HEX2: state <= ST_CR;
               ST_CR:   state <= (byte_in == CH_CR) ? ST_LF : ST_HUNT;
               ST_LF: begin
                  state <= ST_HUNT;
                  if (finish) begin
                     done       <= 1'b1;
                     hour       <= t_pair[0][4:0];
                     minute     <= t_pair[1][5:0];
                     second     <= t_pair[2][5:0];
                     day        <= d_pair[0][4:0];
                     month      <= d_pair[1][3:0];
                     year       <= d_pair[2][6:0];
                     data_valid <= status_r;
                     cksum_ok   <= ck_match;
                     err        <= !(ck_match && t_ok && d_ok && rng_ok);
                  end
               end
               default: state <= ST_HUNT;
            endcase
         end
      end
   end

endmodule

// File: rtl/rmc_tod_parser_chk.sv
module rmc_tod_parser_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] byte_in,
   input logic       byte_vld,
   input logic [4:0] hour,
   input logic [5:0] minute,
   input logic [5:0] second,
   input logic [4:0] day,
   input logic [3:0] month,
   input logic [6:0] year,
   input logic       data_valid,
   input logic       cksum_ok,
   input logic       err,
   input logic       done
);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_after_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(byte_vld && byte_in == 8'h0A));

   // R11
   outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({hour, minute, second, day, month, year,
                         data_valid, cksum_ok, err}));

   // R7
   clean_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (hour < 5'd24 && minute < 6'd60 && second < 6'd60 &&
                          day != 5'd0 && month != 4'd0 && month < 4'd13));

   // R5
   bad_sum_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cksum_ok) |-> err);

endmodule

bind rmc_tod_parser rmc_tod_parser_chk chk_i (
   .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
   .hour(hour), .minute(minute), .second(second), .day(day), .month(month),
   .year(year), .data_valid(data_valid), .cksum_ok(cksum_ok), .err(err),
   .done(done));

// File: tb/rmc_tod_parser_tb.sv
`timescale 1ns/1ps
module rmc_tod_parser_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       byte_vld = 1'b0;
   logic [4:0] hour;
   logic [5:0] minute, second;
   logic [4:0] day;
   logic [3:0] month;
   logic [6:0] year;
   logic       data_valid, cksum_ok, err, done;

   int checks = 0;
   int errors = 0;
   int ndone  = 0;

   always #2.5 clk = ~clk;

   rmc_tod_parser dut_i (
      .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
      .hour(hour), .minute(minute), .second(second), .day(day), .month(month),
      .year(year), .data_valid(data_valid), .cksum_ok(cksum_ok), .err(err),
      .done(done));

   always @(posedge clk) if (rst_n && done) ndone++;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic send_raw(input string s, input bit gap);
      for (int i = 0; i < s.len(); i++) begin
         byte_in  = s[i];
         byte_vld = 1'b1;
         @(negedge clk);
         if (gap && i != s.len() - 1) begin
            byte_vld = 1'b0;
            byte_in  = 8'h24;
            @(negedge clk);
         end
      end
      byte_vld = 1'b0;
   endtask

   task automatic send_frame(input string body, input bit lower,
                             input bit corrupt, input bit gap);
      logic [7:0] x;
      string hx;
      x = 8'h00;
      for (int i = 0; i < body.len(); i++) x = x ^ body[i];
      if (corrupt) x = x ^ 8'h01;
      hx = lower ? $sformatf("%02x", x) : $sformatf("%02X", x);
      send_raw({"$", body, "*", hx, "\r\n"}, gap);
   endtask

   function automatic string mk_body(input string t, input string st, input string d);
      return $sformatf("GPRMC,%s,%s,4916.45,N,12311.12,W,000.5,054.7,%s,020.3,E",
                       t, st, d);
   endfunction

   // send a sentence and judge the done-cycle outputs
   task automatic judge(input string t, input string st, input string d,
                        input bit lower, input bit corrupt, input bit gap,
                        input bit exp_err, input int eh, input int em, input int es,
                        input int ed, input int emo, input int ey, input string tag);
      send_frame(mk_body(t, st, d), lower, corrupt, gap);
      chk(done === 1'b1, tag, "done (R11)", int'(done), 1);
      chk(err === exp_err, tag, "err", int'(err), int'(exp_err));
      chk(cksum_ok === !corrupt, {tag, " R5"}, "cksum_ok", int'(cksum_ok), int'(!corrupt));
      chk(data_valid === (st == "A"), {tag, " R4"}, "data_valid",
          int'(data_valid), int'(st == "A"));
      if (!exp_err) begin
         chk(hour == eh,   {tag, " R2"}, "hour",   int'(hour),   eh);
         chk(minute == em, {tag, " R2"}, "minute", int'(minute), em);
         chk(second == es, {tag, " R2"}, "second", int'(second), es);
         chk(day == ed,    {tag, " R3"}, "day",    int'(day),    ed);
         chk(month == emo, {tag, " R3"}, "month",  int'(month),  emo);
         chk(year == ey,   {tag, " R3"}, "year",   int'(year),   ey);
      end
   endtask

   task automatic run_num(input int h, input int m, input int s, input int d,
                          input int mo, input int y, input string st,
                          input bit lower, input bit corrupt, input bit gap,
                          input string tag);
      bit bad;
      bad = (h > 23) || (m > 59) || (s > 59) || (d < 1) || (d > 31) ||
            (mo < 1) || (mo > 12) || corrupt;
      judge($sformatf("%02d%02d%02d", h, m, s), st,
            $sformatf("%02d%02d%02d", d, mo, y),
            lower, corrupt, gap, bad, h, m, s, d, mo, y, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int nd0;
      logic [4:0] h0;
      repeat (4) @(negedge clk);
      // R1: reset values
      chk(done === 1'b0 && err === 1'b0 && cksum_ok === 1'b0 && data_valid === 1'b0,
          "R1", "flags", int'({done, err, cksum_ok, data_valid}), 0);
      chk({hour, minute, second, day, month, year} === '0, "R1", "values",
          int'({hour, minute, second}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 sweeps, alternating hex case (R6)
      for (int h = 0; h <= 24; h++)
         run_num(h, 54, 46, 19, 11, 94, "A", h[0], 1'b0, 1'b0, "R2 R7 hour");
      for (int m = 0; m <= 60; m++)
         run_num(7, m, 3, 1, 1, 0, "A", m[0], 1'b0, 1'b0, "R2 R7 minute");
      for (int s = 0; s <= 60; s++)
         run_num(23, 59, s, 31, 12, 99, "A", s[0], 1'b0, 1'b0, "R2 R7 second");
      // R3 sweeps
      for (int d = 0; d <= 32; d++)
         run_num(12, 0, 0, d, 6, 21, "A", d[0], 1'b0, 1'b0, "R3 R7 day");
      for (int mo = 0; mo <= 13; mo++)
         run_num(12, 0, 0, 15, mo, 21, "A", mo[0], 1'b0, 1'b0, "R3 R7 month");
      for (int y = 0; y <= 99; y += 7)
         run_num(1, 2, 3, 4, 5, y, "A", 1'b1, 1'b0, 1'b0, "R3 year");

      // R4: warning status
      run_num(22, 54, 46, 19, 11, 94, "V", 1'b0, 1'b0, 1'b0, "R4 warn");
      run_num(22, 54, 46, 19, 11, 94, "", 1'b0, 1'b0, 1'b0, "R4 empty");

      // R5: corrupted checksum, good and bad ranges together
      for (int h = 20; h <= 26; h++)
         run_num(h, 10, 10, 10, 10, 10, "A", h[0], 1'b1, 1'b0, "R5 R7 mix");

      // R8: format faults and tolerated fraction
      judge("12a456", "A", "191194", 1'b0, 1'b0, 1'b0, 1'b1, 0,0,0,0,0,0, "R8 nondigit");
      judge("1234", "A", "191194", 1'b0, 1'b0, 1'b0, 1'b1, 0,0,0,0,0,0, "R8 short");
      judge("225446", "A", "19119", 1'b0, 1'b0, 1'b0, 1'b1, 0,0,0,0,0,0, "R8 shortdate");
      judge("225446.00", "A", "191194", 1'b0, 1'b0, 1'b0, 1'b0,
            22, 54, 46, 19, 11, 94, "R8 R2 fraction");

      // R12: idle gaps between bytes
      judge("083015", "A", "290208", 1'b1, 1'b0, 1'b1, 1'b0,
            8, 30, 15, 29, 2, 8, "R12 gaps");

      // R9: leading junk and mid-sentence restart
      nd0 = ndone;
      send_raw("xx#,*\r\n$GPRMC,1234", 1'b0);
      judge("010203", "V", "040506", 1'b0, 1'b0, 1'b0, 1'b0,
            1, 2, 3, 4, 5, 6, "R9 restart");
      chk(ndone == nd0 + 1, "R9", "done count", ndone - nd0, 1);

      // R11: outputs hold while idle
      h0 = hour;
      repeat (6) @(negedge clk);
      chk(done === 1'b0 && hour == h0, "R11", "hold hour", int'(hour), int'(h0));

      // R11: missing CR before LF gives no done
      nd0 = ndone;
      send_raw("$GPRMC,111111,A,,,,,,,111111,,*00\n", 1'b0);
      repeat (3) @(negedge clk);
      chk(ndone == nd0, "R11", "no done without CR", ndone - nd0, 0);

      // R10: other identifier
      nd0 = ndone;
      send_frame("GPGGA,123519,4807.038,N,01131.000,E,1,08,0.9,545.4,M,,,,", 1'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      chk(ndone == nd0, "R10", "done count", ndone - nd0, 0);
      chk(hour == h0 && minute == 2 && day == 4, "R10", "hour held", int'(hour), int'(h0));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule